// File: doc/BRIEF.md
# PC Card Function Configuration Gate

This block holds the 8-bit configuration option register for one function of a multifunction PC Card. The host writes and reads it through a simple register port. Its stored bits decide whether the function's host-side signals reach the card edge:
- the interrupt request,
- the I/O input acknowledge,
- the 16-bit I/O indication,
- the attribute memory write strobe.

The same bits also produce a soft reset pulse for the function's other registers, and they control the power state of the function core.

The host address decoder, the function core and the attribute memory are outside this block. The block receives their results as inputs: an I/O cycle flag, an address match, a 16-bit mode flag, a wake-receive enable, the raw core interrupt and the raw attribute write request. It returns the gated, active-low card signals together with enable, reset and power controls. All gating is combinational from the stored register. The soft reset is the only output that is registered.

Top module: `pccard_fn_cfg`

## Requirements
- R1: After reset the register reads 0x40, n_ireq is high, soft_rst is low and pwr_down is high.
- R2: Reads return bits 3..0 as last written. Bit 6 always reads 1 (level interrupts). Bits 7, 5 and 4 always read 0, whatever was written to them.
- R3: A write with bit 7 set raises soft_rst for exactly the one cycle after the write edge. The other bits of that write are stored as usual. A write with bit 7 clear never raises soft_rst.
- R4: n_ireq is low exactly when core_irq, bit 0 (function enable) and bit 2 (interrupt routing) are all 1.
- R5: attr_wr_gated equals attr_wr_req when bit 3 is 1, and is 0 when bit 3 is 0.
- R6: With bit 1 (on-board decoder) set, fn_access is 1 and n_inpack is 0 only when io_cycle, addr_hit and bit 0 are all 1.
- R7: With bit 1 clear, fn_access is 1 and n_inpack is 0 whenever io_cycle and bit 0 are 1, whatever the value of addr_hit.
- R8: With bit 1 clear, n_iois16 is low whenever bit 0 and mode16 are 1, even outside I/O cycles.
- R9: With bit 1 set, n_iois16 is low only when io_cycle, addr_hit, mode16 and bit 0 are all 1.
- R10: pwr_down is the inverse of bit 0. rx_pwr_on is 1 when bit 0 is 1 or wake_rx_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| io_cycle | input | 1 | Host I/O cycle in progress |
| addr_hit | input | 1 | On-board decoder address match |
| mode16 | input | 1 | Function configured for 16-bit I/O |
| wake_rx_en | input | 1 | Wake-on-packet receive enabled |
| core_irq | input | 1 | Raw interrupt from the function core |
| attr_wr_req | input | 1 | Raw attribute memory write strobe |
| attr_wr_gated | output | 1 | Attribute write strobe after gating |
| n_ireq | output | 1 | Interrupt request, active low |
| n_inpack | output | 1 | I/O input acknowledge, active low |
| n_iois16 | output | 1 | 16-bit I/O indication, active low |
| fn_access | output | 1 | Function register access enabled |
| soft_rst | output | 1 | One-cycle soft reset to function registers |
| pwr_down | output | 1 | Function core powered down |
| rx_pwr_on | output | 1 | Receive path kept powered |

## Verification
The case hardest to reach from the ports is a decoder-bypass configuration with the function enabled and 16-bit mode set. In that case n_iois16 must stay asserted while no I/O cycle is running, which a sweep driven only by I/O cycles never shows. The bench therefore walks every value of the four stored bits. For each value it applies all 64 combinations of the six side inputs, including those with io_cycle low. It also performs a write that combines bit 7 with ordinary bits, to show that the pulse and the stored bits coexist.

// File: rtl/pccard_cfg_pkg.sv
package pccard_cfg_pkg;
  localparam int B_FN   = 0;
  localparam int B_DEC  = 1;
  localparam int B_IRQ  = 2;
  localparam int B_ATTR = 3;
  localparam int B_LEV  = 6;
  localparam int B_SRST = 7;

  typedef struct packed {
    logic attr_we;
    logic irq_en;
    logic dec_en;
    logic fn_en;
  } cfg_t;

  // Function selected for the current host cycle.
  function automatic logic host_sel(cfg_t c, logic io_cyc, logic hit);
    return c.fn_en & io_cyc & (hit | ~c.dec_en);
  endfunction

  // 16-bit indication, active high.
  function automatic logic wide_ind(cfg_t c, logic m16, logic io_cyc, logic hit);
    return c.fn_en & m16 & (c.dec_en ? (io_cyc & hit) : 1'b1);
  endfunction
endpackage

// File: rtl/pccard_cfg_reg.sv
module pccard_cfg_reg
  import pccard_cfg_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  output cfg_t             cfg,
  output logic [CFG_W-1:0] rdata,
  output logic             srst_pulse
);
  localparam int HI = CFG_W - 1;

  cfg_t cfg_q;
  logic srst_q;
  logic wr_srst;
  logic unused_wbits;

  assign wr_srst      = wr_en & wdata[B_SRST];
  assign unused_wbits = ^{wdata[HI:B_ATTR+1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      srst_q <= 1'b0;
    end else begin
      srst_q <= wr_srst;
      if (wr_en) begin
        cfg_q.fn_en   <= wdata[B_FN];
        cfg_q.dec_en  <= wdata[B_DEC];
        cfg_q.irq_en  <= wdata[B_IRQ];
        cfg_q.attr_we <= wdata[B_ATTR];
      end
    end
  end

  always_comb begin
    rdata         = '0;
    rdata[B_FN]   = cfg_q.fn_en;
    rdata[B_DEC]  = cfg_q.dec_en;
    rdata[B_IRQ]  = cfg_q.irq_en;
    rdata[B_ATTR] = cfg_q.attr_we;
    rdata[B_LEV]  = 1'b1;
  end

  assign cfg        = cfg_q;
  assign srst_pulse = srst_q;

  p_srst_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    srst_pulse |-> $past(wr_en && wdata[B_SRST]));
  p_rd_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[B_LEV] && !rdata[B_SRST] && (rdata[5:4] == 2'b00));
endmodule

// File: rtl/pccard_host_gate.sv
module pccard_host_gate
  import pccard_cfg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cfg_t cfg,
  input  logic io_cycle,
  input  logic addr_hit,
  input  logic mode16,
  input  logic core_irq,
  input  logic attr_wr_req,
  output logic attr_wr_gated,
  output logic n_ireq,
  output logic n_inpack,
  output logic n_iois16,
  output logic fn_access
);
  logic sel;
  logic wide;

  assign sel           = host_sel(cfg, io_cycle, addr_hit);
  assign wide          = wide_ind(cfg, mode16, io_cycle, addr_hit);
  assign fn_access     = sel;
  assign n_inpack      = ~sel;
  assign n_iois16      = ~wide;
  assign n_ireq        = ~(core_irq & cfg.fn_en & cfg.irq_en);
  assign attr_wr_gated = attr_wr_req & cfg.attr_we;

  p_irq_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.irq_en || !cfg.fn_en) |-> n_ireq);
  p_attr_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.attr_we |-> !attr_wr_gated);
  p_inpack_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.dec_en && !addr_hit) |-> (n_inpack && n_iois16));
  p_iois16_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.dec_en && cfg.fn_en && mode16) |-> !n_iois16);
endmodule

// File: rtl/pccard_pwr_ctl.sv
module pccard_pwr_ctl
  import pccard_cfg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cfg_t cfg,
  input  logic wake_rx_en,
  output logic pwr_down,
  output logic rx_pwr_on
);
  assign pwr_down  = ~cfg.fn_en;
  assign rx_pwr_on = cfg.fn_en | wake_rx_en;

  p_rx_alive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_rx_en |-> rx_pwr_on);
endmodule

// File: rtl/pccard_fn_cfg.sv
module pccard_fn_cfg
  import pccard_cfg_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [CFG_W-1:0] reg_wdata,
  output logic [CFG_W-1:0] reg_rdata,
  input  logic             io_cycle,
  input  logic             addr_hit,
  input  logic             mode16,
  input  logic             wake_rx_en,
  input  logic             core_irq,
  input  logic             attr_wr_req,
  output logic             attr_wr_gated,
  output logic             n_ireq,
  output logic             n_inpack,
  output logic             n_iois16,
  output logic             fn_access,
  output logic             soft_rst,
  output logic             pwr_down,
  output logic             rx_pwr_on
);
  cfg_t cfg_w;

  pccard_cfg_reg #(.CFG_W(CFG_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wdata(reg_wdata),
    .cfg(cfg_w), .rdata(reg_rdata), .srst_pulse(soft_rst)
  );

  pccard_host_gate u_gate (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_w), .io_cycle(io_cycle),
    .addr_hit(addr_hit), .mode16(mode16), .core_irq(core_irq),
    .attr_wr_req(attr_wr_req), .attr_wr_gated(attr_wr_gated),
    .n_ireq(n_ireq), .n_inpack(n_inpack), .n_iois16(n_iois16),
    .fn_access(fn_access)
  );

  pccard_pwr_ctl u_pwr (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_w), .wake_rx_en(wake_rx_en),
    .pwr_down(pwr_down), .rx_pwr_on(rx_pwr_on)
  );

  p_access_powered_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fn_access |-> (!pwr_down && io_cycle && !n_inpack));
endmodule

// File: tb/pccard_fn_cfg_bench.sv
module pccard_fn_cfg_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic io_cycle = 0, addr_hit = 0, mode16 = 0, wake_rx_en = 0, core_irq = 0, attr_wr_req = 0;
  logic attr_wr_gated, n_ireq, n_inpack, n_iois16, fn_access, soft_rst, pwr_down, rx_pwr_on;
  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  pccard_fn_cfg u_pccard_fn_cfg (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .io_cycle(io_cycle), .addr_hit(addr_hit), .mode16(mode16), .wake_rx_en(wake_rx_en),
    .core_irq(core_irq), .attr_wr_req(attr_wr_req), .attr_wr_gated(attr_wr_gated),
    .n_ireq(n_ireq), .n_inpack(n_inpack), .n_iois16(n_iois16), .fn_access(fn_access),
    .soft_rst(soft_rst), .pwr_down(pwr_down), .rx_pwr_on(rx_pwr_on)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
    #2;
  endtask

  initial begin
    #4000000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    // R1 reset state
    chk("R1 rdata", reg_rdata, 8'h40);
    chk("R1 n_ireq", {7'd0, n_ireq}, 8'd1);
    chk("R1 soft_rst", {7'd0, soft_rst}, 8'd0);
    chk("R1 pwr_down", {7'd0, pwr_down}, 8'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reserved bits ignored
    wr(8'h70);
    chk("R2 reserved", reg_rdata, 8'h40);

    // R3 soft reset pulse with ordinary bits in same write
    wr(8'h85);
    chk("R3 pulse", {7'd0, soft_rst}, 8'd1);
    chk("R3 stored", reg_rdata, 8'h45);
    @(negedge clk); #2;
    chk("R3 one cycle", {7'd0, soft_rst}, 8'd0);
    chk("R3 self clear", reg_rdata, 8'h45);

    for (int c = 0; c < 16; c++) begin
      logic fe, de, ie, ae;
      wr(8'(c));
      fe = c[0]; de = c[1]; ie = c[2]; ae = c[3];
      chk("R2 readback", reg_rdata, 8'h40 + 8'(c));
      chk("R3 no pulse", {7'd0, soft_rst}, 8'd0);
      for (int v = 0; v < 64; v++) begin
        logic io, ht, m, w, irq, ar, acc, wide;
        io = v[0]; ht = v[1]; m = v[2]; w = v[3]; irq = v[4]; ar = v[5];
        io_cycle = io; addr_hit = ht; mode16 = m; wake_rx_en = w;
        core_irq = irq; attr_wr_req = ar;
        #3;
        chk("R4 n_ireq", {7'd0, n_ireq}, {7'd0, !(irq && fe && ie)});
        chk("R5 attr", {7'd0, attr_wr_gated}, {7'd0, ar && ae});
        if (de) begin
          acc = io && ht && fe;
          wide = io && ht && m && fe;
          chk("R6 fn_access", {7'd0, fn_access}, {7'd0, acc});
          chk("R6 n_inpack", {7'd0, n_inpack}, {7'd0, !acc});
          chk("R9 n_iois16", {7'd0, n_iois16}, {7'd0, !wide});
        end else begin
          acc = io && fe;
          wide = fe && m;
          chk("R7 fn_access", {7'd0, fn_access}, {7'd0, acc});
          chk("R7 n_inpack", {7'd0, n_inpack}, {7'd0, !acc});
          chk("R8 n_iois16", {7'd0, n_iois16}, {7'd0, !wide});
        end
        chk("R10 pwr_down", {7'd0, pwr_down}, {7'd0, !fe});
        chk("R10 rx_pwr_on", {7'd0, rx_pwr_on}, {7'd0, fe || w});
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule